// File: doc/BRIEF.md
# Sliding Window Line Buffer

This block sits at the front of a neighbourhood image operator such as grayscale dilation or erosion. It accepts a raster stream of 8-bit pixels, at most one per clock, marked with a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of each row. For every accepted pixel it produces one square neighbourhood centred on that pixel. The window is 3×3, 5×5 or 7×7, selected by a configuration code. Earlier rows are held in six line memories whose used depth equals the configured image width. A shift-register array holds the newest columns, and a tap multiplexer places the selected n×n sub-window in the centre of a fixed 7×7 output bus.

Every output tap has its own flag that tells whether the neighbour lies inside both the selected window and the image. A consumer can therefore ignore out-of-frame neighbours without tracking coordinates itself. The right-hand columns and bottom rows that have not yet produced an output are flushed by internal padding steps. These steps run in the idle cycles after each end-of-line pixel and after the frame's last row, so the frame yields exactly as many windows as it had pixels. The width, height and window code are captured with the start-of-frame pixel.

Top module: `sliding_window_buffer`

## Requirements
- R1: While reset is high and in the cycles that follow it until a frame is fed, `win_valid` stays low.
- R2: The window code selects the size: 0 gives 3×3, 1 gives 5×5, and both 2 and 3 give 7×7. Output tap (i,j), with i the row from the top and j the column from the left (both 0..6), sits in byte i*7+j of `win_data` and bit i*7+j of `win_inside`. It refers to the pixel at row `ctr_y`+i−3, column `ctr_x`+j−3. Taps outside the selected n×n square centred on tap (3,3) always have flag 0.
- R3: Every tap whose flag is 1 carries the input pixel at that tap's image coordinate.
- R4: A tap flag is 1 exactly when the tap lies inside the selected square and its coordinate lies inside the image (0 ≤ column < width, 0 ≤ row < height). A tap with flag 0 carries data 0. The centre flag is always 1.
- R5: Each accepted pixel yields exactly one window, and windows appear in raster order. `ctr_x` and `ctr_y` give the centre column and row.
- R6: With r = (n−1)/2, the source keeps `pix_valid` low for at least r cycles after each end-of-line pixel, and for at least r·(width+r+1)+2 cycles after the frame's last pixel. Within that time every remaining window of the frame is produced. Idle cycles between pixels of a line are allowed.
- R7: Width, height and window code are sampled with the start-of-frame pixel. Changing them later in the frame has no effect on that frame's windows.
- R8: Any width from 1 up to the maximum of 1024 is handled, including images smaller than the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Pixel intensity |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| cfg_width | input | 11 | Pixels per row, 1..1024 |
| cfg_height | input | 11 | Rows per frame |
| cfg_win | input | 2 | Window size code |
| win_valid | output | 1 | Window outputs hold a new window |
| win_data | output | 392 | 49 taps of 8 bits, tap i*7+j at byte i*7+j |
| win_inside | output | 49 | Per-tap in-window and in-image flag |
| ctr_x | output | 11 | Centre column |
| ctr_y | output | 11 | Centre row |

## Verification
A line-memory chain that slips by one line shows up in the first window whose taps reach more than one row upward: the taps carry a pixel from the wrong row. A fault in the tap multiplexer or the radius decode shows up in the first window of the frame, as flags set outside the selected square or as data that is not zero. A scan counter that mishandles padding breaks the raster order of the centres at the next row boundary. It leaves windows undelivered, or delivers extra ones, by the end of the flush. A corner window with a wrong in-image test fails as soon as the first row is complete.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE,
    SCAN_LINE,
    SCAN_PADC,
    SCAN_PADR
  } scan_state_e;

  // Window radius for a size code, saturated at the largest supported radius.
  function automatic int unsigned code_to_radius(input logic [1:0] code, input int unsigned rad_max);
    int unsigned rv;
    rv = int'(code) + 1;
    return (rv > rad_max) ? rad_max : rv;
  endfunction

endpackage

// File: rtl/swb_line_mem.sv
module swb_line_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  parameter int AW    = 10
)(
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/swb_scan_ctrl.sv
module swb_scan_ctrl import swb_pkg::*; #(
  parameter int PIX_W   = 8,
  parameter int XW      = 11,
  parameter int YW      = 11,
  parameter int RW      = 2,
  parameter int RAD_MAX = 3,
  parameter int AW      = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_sof,
  input  logic             pix_eol,
  input  logic [XW-1:0]    cfg_width,
  input  logic [YW-1:0]    cfg_height,
  input  logic [1:0]       cfg_win,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             st_v,
  output logic [PIX_W-1:0] st_pix,
  output logic [XW-1:0]    st_x,
  output logic [YW-1:0]    st_y,
  output logic             st_mem,
  output logic [XW-1:0]    lat_w,
  output logic [YW-1:0]    lat_h,
  output logic [RW-1:0]    lat_r
);

  scan_state_e st_q;
  logic [XW-1:0] sx_q;
  logic [YW-1:0] sy_q;

  logic          start, real_step, pad_step, step, last_col;
  logic [XW-1:0] cx, cur_w, row_end;
  logic [YW-1:0] cy;
  logic [RW-1:0] cur_r;

  // One scan step per accepted pixel or per internal padding position.
  always_comb begin
    start     = pix_valid && pix_sof && (st_q == SCAN_IDLE || st_q == SCAN_LINE);
    real_step = start || (pix_valid && st_q == SCAN_LINE);
    pad_step  = (st_q == SCAN_PADC) || (st_q == SCAN_PADR);
    step      = real_step || pad_step;
    cur_w     = start ? cfg_width : lat_w;
    cur_r     = start ? RW'(code_to_radius(cfg_win, RAD_MAX)) : lat_r;
    cx        = start ? '0 : sx_q;
    cy        = start ? '0 : sy_q;
    row_end   = cur_w + XW'(cur_r) - XW'(1);
    last_col  = (cx == row_end);
    rd_en     = step && (cx < cur_w);
    rd_addr   = cx[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SCAN_IDLE;
      sx_q   <= '0;
      sy_q   <= '0;
      lat_w  <= '0;
      lat_h  <= '0;
      lat_r  <= RW'(1);
      st_v   <= 1'b0;
      st_pix <= '0;
      st_x   <= '0;
      st_y   <= '0;
      st_mem <= 1'b0;
    end else begin
      st_v   <= step;
      st_pix <= real_step ? pix_data : '0;
      st_x   <= cx;
      st_y   <= cy;
      st_mem <= rd_en;
      if (start) begin
        lat_w <= cfg_width;
        lat_h <= cfg_height;
        lat_r <= cur_r;
      end
      if (real_step) begin
        sy_q <= cy;
        if (pix_eol) begin
          st_q <= SCAN_PADC;
          sx_q <= cur_w;
        end else begin
          st_q <= SCAN_LINE;
          sx_q <= cx + XW'(1);
        end
      end else if (pad_step) begin
        if (!last_col) begin
          sx_q <= sx_q + XW'(1);
        end else begin
          sx_q <= '0;
          sy_q <= sy_q + YW'(1);
          if (st_q == SCAN_PADC) begin
            st_q <= (sy_q == lat_h - YW'(1)) ? SCAN_PADR : SCAN_LINE;
          end else if (sy_q == lat_h + YW'(lat_r) - YW'(1)) begin
            st_q <= SCAN_IDLE;
            sy_q <= '0;
          end
        end
      end
    end
  end

  // R6: the source stays idle while padding steps run.
  p_flush_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == SCAN_PADC || st_q == SCAN_PADR) |-> !pix_valid);

  // R7: frame configuration changes only with a start-of-frame pixel.
  p_cfg_frame_r7: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(lat_r) && $stable(lat_w) && $stable(lat_h)));

endmodule

// File: rtl/swb_window.sv
module swb_window #(
  parameter int PIX_W = 8,
  parameter int MAX_N = 7,
  parameter int XW    = 11,
  parameter int YW    = 11,
  parameter int RW    = 2
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sh_v,
  input  logic [MAX_N*PIX_W-1:0]       col,
  input  logic [XW-1:0]                st_x,
  input  logic [YW-1:0]                st_y,
  input  logic [XW-1:0]                lat_w,
  input  logic [YW-1:0]                lat_h,
  input  logic [RW-1:0]                lat_r,
  output logic                         win_valid,
  output logic [MAX_N*MAX_N*PIX_W-1:0] win_data,
  output logic [MAX_N*MAX_N-1:0]       win_inside,
  output logic [XW-1:0]                ctr_x,
  output logic [YW-1:0]                ctr_y
);

  localparam int RAD  = (MAX_N - 1) / 2;
  localparam int CEN  = RAD * MAX_N + RAD;
  localparam int IW   = $clog2(MAX_N);
  localparam int TAPS = MAX_N * MAX_N;

  logic [PIX_W-1:0] win_q [MAX_N][MAX_N];

  // Newest column enters on the right, row MAX_N-1 is the newest line.
  always_ff @(posedge clk) begin
    if (sh_v) begin
      for (int rr = 0; rr < MAX_N; rr++) begin
        for (int cc = 0; cc < MAX_N - 1; cc++) win_q[rr][cc] <= win_q[rr][cc+1];
        win_q[rr][MAX_N-1] <= col[rr*PIX_W +: PIX_W];
      end
    end
  end

  // Centre lags the newest pixel by the radius in both directions.
  logic          s2_v, s2_ok;
  logic [XW-1:0] s2_x;
  logic [YW-1:0] s2_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v  <= 1'b0;
      s2_ok <= 1'b0;
      s2_x  <= '0;
      s2_y  <= '0;
    end else begin
      s2_v  <= sh_v;
      s2_ok <= (st_x >= XW'(lat_r)) && (st_y >= YW'(lat_r));
      s2_x  <= st_x - XW'(lat_r);
      s2_y  <= st_y - YW'(lat_r);
    end
  end

  logic [TAPS-1:0]       tap_in;
  logic [TAPS*PIX_W-1:0] tap_px;

  for (genvar ti = 0; ti < MAX_N; ti++) begin : g_row
    for (genvar tj = 0; tj < MAX_N; tj++) begin : g_col
      localparam int DR = ti - RAD;
      localparam int DC = tj - RAD;
      localparam int AR = (DR < 0) ? -DR : DR;
      localparam int AC = (DC < 0) ? -DC : DC;
      localparam int K  = ti * MAX_N + tj;
      int          yy, xx;
      logic        inside_w;
      logic [IW-1:0] ri, ci;
      assign yy = int'(s2_y) + DR;
      assign xx = int'(s2_x) + DC;
      assign ri = IW'(ti + RAD - int'(lat_r));
      assign ci = IW'(tj + RAD - int'(lat_r));
      assign inside_w = (AR <= int'(lat_r)) && (AC <= int'(lat_r)) &&
                        (yy >= 0) && (yy < int'(lat_h)) && (xx >= 0) && (xx < int'(lat_w));
      assign tap_in[K] = inside_w;
      assign tap_px[K*PIX_W +: PIX_W] = inside_w ? win_q[ri][ci] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid  <= 1'b0;
      win_data   <= '0;
      win_inside <= '0;
      ctr_x      <= '0;
      ctr_y      <= '0;
    end else begin
      win_valid <= s2_v && s2_ok;
      if (s2_v && s2_ok) begin
        win_data   <= tap_px;
        win_inside <= tap_in;
        ctr_x      <= s2_x;
        ctr_y      <= s2_y;
      end
    end
  end

  // R4: the centre pixel is always a valid neighbour.
  p_centre_flag_r4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_inside[CEN]);

  // R2: never more flagged taps than the selected square holds.
  p_tap_count_r2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ($countones(win_inside) <= (2*int'(lat_r)+1)*(2*int'(lat_r)+1)));

  // R5: back-to-back windows on one row advance by one column.
  p_raster_r5: assert property (@(posedge clk) disable iff (rst)
    (win_valid && $past(win_valid) && ctr_x != '0) |->
      (ctr_x == $past(ctr_x) + XW'(1) && ctr_y == $past(ctr_y)));

  // R5: reported centres lie inside the image.
  p_ctr_range_r5: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (ctr_x < lat_w && ctr_y < lat_h));

endmodule

// File: rtl/sliding_window_buffer.sv
module sliding_window_buffer #(
  parameter int PIX_W      = 8,
  parameter int MAX_WIDTH  = 1024,
  parameter int MAX_HEIGHT = 1024,
  parameter int MAX_N      = 7,
  localparam int XW        = $clog2(MAX_WIDTH + MAX_N),
  localparam int YW        = $clog2(MAX_HEIGHT + MAX_N)
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pix_valid,
  input  logic [PIX_W-1:0]             pix_data,
  input  logic                         pix_sof,
  input  logic                         pix_eol,
  input  logic [XW-1:0]                cfg_width,
  input  logic [YW-1:0]                cfg_height,
  input  logic [1:0]                   cfg_win,
  output logic                         win_valid,
  output logic [MAX_N*MAX_N*PIX_W-1:0] win_data,
  output logic [MAX_N*MAX_N-1:0]       win_inside,
  output logic [XW-1:0]                ctr_x,
  output logic [YW-1:0]                ctr_y
);

  localparam int RAD_MAX = (MAX_N - 1) / 2;
  localparam int NLINE   = MAX_N - 1;
  localparam int RW      = $clog2(RAD_MAX + 1);
  localparam int AW      = $clog2(MAX_WIDTH);

  logic             rd_en, st_v, st_mem;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] st_pix;
  logic [XW-1:0]    st_x, lat_w;
  logic [YW-1:0]    st_y, lat_h;
  logic [RW-1:0]    lat_r;

  swb_scan_ctrl #(
    .PIX_W(PIX_W), .XW(XW), .YW(YW), .RW(RW), .RAD_MAX(RAD_MAX), .AW(AW)
  ) u_scan (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_win(cfg_win), .rd_en(rd_en), .rd_addr(rd_addr),
    .st_v(st_v), .st_pix(st_pix), .st_x(st_x), .st_y(st_y), .st_mem(st_mem),
    .lat_w(lat_w), .lat_h(lat_h), .lat_r(lat_r)
  );

  logic [NLINE*PIX_W-1:0] lm_rd;
  logic [MAX_N*PIX_W-1:0] col;

  // Line k holds the row k+1 above the newest; each writes what the one above it read.
  for (genvar k = 0; k < NLINE; k++) begin : g_line
    logic [PIX_W-1:0] wr_d;
    if (k == 0) begin : g_first
      assign wr_d = st_pix;
    end else begin : g_next
      assign wr_d = lm_rd[(k-1)*PIX_W +: PIX_W];
    end
    swb_line_mem #(.DEPTH(MAX_WIDTH), .DW(PIX_W), .AW(AW)) u_mem (
      .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(lm_rd[k*PIX_W +: PIX_W]),
      .wr_en(st_mem), .wr_addr(st_x[AW-1:0]), .wr_data(wr_d)
    );
    assign col[(NLINE-1-k)*PIX_W +: PIX_W] = st_mem ? lm_rd[k*PIX_W +: PIX_W] : '0;
  end
  assign col[NLINE*PIX_W +: PIX_W] = st_pix;

  swb_window #(
    .PIX_W(PIX_W), .MAX_N(MAX_N), .XW(XW), .YW(YW), .RW(RW)
  ) u_win (
    .clk(clk), .rst(rst), .sh_v(st_v), .col(col), .st_x(st_x), .st_y(st_y),
    .lat_w(lat_w), .lat_h(lat_h), .lat_r(lat_r), .win_valid(win_valid),
    .win_data(win_data), .win_inside(win_inside), .ctr_x(ctr_x), .ctr_y(ctr_y)
  );

endmodule

// File: tb/sliding_window_buffer_tb_top.sv
module sliding_window_buffer_tb_top;

  localparam int PW   = 8;
  localparam int N    = 7;
  localparam int RAD  = 3;
  localparam int XW   = 11;
  localparam int YW   = 11;
  localparam int TAPS = N * N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst, pix_valid, pix_sof, pix_eol;
  logic [PW-1:0]        pix_data;
  logic [XW-1:0]        cfg_width;
  logic [YW-1:0]        cfg_height;
  logic [1:0]           cfg_win;
  logic                 win_valid;
  logic [TAPS*PW-1:0]   win_data;
  logic [TAPS-1:0]      win_inside;
  logic [XW-1:0]        ctr_x;
  logic [YW-1:0]        ctr_y;

  sliding_window_buffer dut_i (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_win(cfg_win), .win_valid(win_valid),
    .win_data(win_data), .win_inside(win_inside), .ctr_x(ctr_x), .ctr_y(ctr_y)
  );

  typedef struct packed {
    logic [XW-1:0]      x;
    logic [YW-1:0]      y;
    logic [TAPS*PW-1:0] d;
    logic [TAPS-1:0]    f;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic logic [7:0] pix_at(int x, int y, int seed);
    return 8'((x * 37 + y * 101 + seed * 13 + x * y) ^ (seed * 8));
  endfunction

  task automatic chk(input bit ok, input string req, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic push_expected(int w, int h, int r, int seed);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        exp_t e;
        e.x = XW'(x);
        e.y = YW'(y);
        e.d = '0;
        e.f = '0;
        for (int i = 0; i < N; i++) begin
          for (int j = 0; j < N; j++) begin
            int dr, dc, yy, xx, adr, adc;
            dr  = i - RAD;
            dc  = j - RAD;
            adr = (dr < 0) ? -dr : dr;
            adc = (dc < 0) ? -dc : dc;
            yy  = y + dr;
            xx  = x + dc;
            if (adr <= r && adc <= r && yy >= 0 && yy < h && xx >= 0 && xx < w) begin
              e.f[i*N+j] = 1'b1;
              e.d[(i*N+j)*PW +: PW] = pix_at(xx, yy, seed);
            end
          end
        end
        exp_q.push_back(e);
      end
    end
  endtask

  // Driver: config is set before the start pixel, then disturbed mid-frame (R7).
  task automatic drive_frame(int w, int h, int code, int seed, int alt_code, int alt_w, bit gaps);
    int r;
    r = (code >= 2) ? 3 : code + 1;
    push_expected(w, h, r, seed);
    @(negedge clk);
    cfg_width  = XW'(w);
    cfg_height = YW'(h);
    cfg_win    = 2'(code);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        pix_valid = 1'b1;
        pix_sof   = (x == 0 && y == 0);
        pix_eol   = (x == w - 1);
        pix_data  = pix_at(x, y, seed);
        @(negedge clk);
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_eol   = 1'b0;
        if (x == 0 && y == 0) begin
          cfg_win    = 2'(alt_code);
          cfg_width  = XW'(alt_w);
          cfg_height = YW'(h + 2);
        end
        if (x == w - 1) repeat (RAD) @(negedge clk);
        else if (gaps && ((x + y) % 3 == 1)) @(negedge clk);
      end
    end
    repeat (r * (w + r) + 8) @(negedge clk);
    // R6 and R5: every window of the frame has been delivered after the flush
    chk(exp_q.size() == 0, "R6 R5 pending windows after flush",
        $sformatf("%0d", exp_q.size()), "0");
  endtask

  // Monitor: compare every produced window against the scoreboard.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && win_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected window",
              $sformatf("x=%0d y=%0d", ctr_x, ctr_y), "none");
        end else begin
          e = exp_q.pop_front();
          chk(ctr_x == e.x && ctr_y == e.y, "R5 centre coordinate",
              $sformatf("x=%0d y=%0d", ctr_x, ctr_y), $sformatf("x=%0d y=%0d", e.x, e.y));
          chk(win_inside == e.f, "R2 R4 tap flags",
              $sformatf("%h", win_inside), $sformatf("%h", e.f));
          chk(win_data == e.d, "R3 R4 tap data",
              $sformatf("%h", win_data), $sformatf("%h", e.d));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst        = 1'b1;
    pix_valid  = 1'b0;
    pix_sof    = 1'b0;
    pix_eol    = 1'b0;
    pix_data   = '0;
    cfg_width  = XW'(8);
    cfg_height = YW'(6);
    cfg_win    = 2'd0;
    repeat (5) @(negedge clk);
    // R1: no window while in reset
    chk(win_valid == 1'b0, "R1 valid during reset", $sformatf("%0b", win_valid), "0");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: still quiet after reset with no input
    chk(win_valid == 1'b0, "R1 valid after reset", $sformatf("%0b", win_valid), "0");

    // R2 3x3 with line gaps; R7 size and width changed mid-frame
    drive_frame(8, 6, 0, 1, 2, 5, 1'b1);
    // R2 5x5; R7 change toward 3x3
    drive_frame(6, 5, 1, 2, 0, 9, 1'b0);
    // R8 7x7 window larger than the image
    drive_frame(4, 3, 2, 3, 1, 2, 1'b1);
    // R2 code 3 maps to 7x7; R8 single-column image
    drive_frame(1, 3, 3, 4, 0, 6, 1'b0);
    // R8 full-width lines, deepest line memory use
    drive_frame(1024, 4, 2, 5, 0, 17, 1'b0);
    // R6 single-row frame, 5x5
    drive_frame(7, 1, 1, 6, 2, 3, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule